// File: doc/BRIEF.md
# Column and Sector Clock Selector

This block routes clocks down one column of a cell array. A column-level multiplexer chooses one of eight global clock lines. On the leftmost or rightmost column it can also choose one of two fast clocks that belong to that edge. The column is divided into sectors of four cells. Each sector has its own selector. It takes either the column clock or that sector's express-bus line, and then passes the signal unchanged, passes it inverted, or forces it low. Forcing a sector low turns off the clock in a sector that holds no clocked logic, which saves power.

The data path is purely combinational. A small register file holds the selections and is written through an address/data/write-enable port. A configured flag in that file keeps every sector output low until software sets it. Cell registers capture on the rising edge, so a sector in pass mode gives rising-edge capture and a sector in invert mode gives falling-edge capture. A parameter selects the interior, left-edge or right-edge variant.

Top module: `colclk_router`

## Requirements
- R1: A synchronous active-low reset clears the configured flag, the column select, every sector mode and every sector source bit. While reset is held, and after it is released, every sector output is 0 until the block is configured again.
- R2: While the configured flag is 0, every sector output is 0, whatever the other settings and inputs are. Once the flag is 1, the outputs follow the sector settings.
- R3: Column select codes 0 to 7 route `glb_clk[code]` to the column clock.
- R4: Codes 8 and 9 route `fck_left[code-8]` on the left-edge variant (EDGE_KIND=1) and `fck_right[code-8]` on the right-edge variant (EDGE_KIND=2). On the interior variant (EDGE_KIND=0) these codes give a column clock of 0. A variant never uses the fast pair that belongs to the other edge.
- R5: Column select codes 10 to 15 give a column clock of 0 on every variant.
- R6: Sector mode 2'b01 passes the sector source unchanged. Mode 2'b10 passes its inverse. Modes 2'b00 and 2'b11 force the output to 0.
- R7: A sector source bit of 0 takes the column clock. A source bit of 1 takes `express[k]` for sector k.
- R8: Register map. Address 0 holds the column select in data bits [3:0] and the configured flag in bit 4. Address 1+k holds sector k, with the mode in bits [1:0] and the source bit in bit 2. A write to any address above the number of sectors changes no output.
- R9: Each sector output depends only on its own sector register and its own express line. Sectors set to different modes at the same time each give their own result.
- R10: A cycle with `cfg_we` low changes no setting, whatever address and data are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Configuration register address |
| cfg_wdata | input | 5 | Configuration write data |
| glb_clk | input | 8 | Global clock lines |
| fck_left | input | 2 | Fast clocks of the left edge |
| fck_right | input | 2 | Fast clocks of the right edge |
| express | input | NUM_CELLS/CELLS_PER_SECTOR | Express-bus line for each sector |
| sec_clk | output | NUM_CELLS/CELLS_PER_SECTOR | Clock delivered to each sector |

## Verification
The configured-flag hold and the per-sector mode both decide a sector output at the same moment. Any sector output is the result of both. The bench writes the flag while the sectors are already set to a mix of pass, invert and zero modes and the column clock is high. It then checks that the outputs go from all zero to exactly the mode results. It also clears the flag again and checks that every sector drops back to zero. All three variants are instantiated side by side on the same stimulus. A shadow model computes each expected vector, so a fast-clock code is judged in the same cycle on an edge column and on an interior column.

// File: rtl/colclk_pkg.sv
package colclk_pkg;

  localparam int EDGE_INTERIOR = 0;
  localparam int EDGE_LEFT     = 1;
  localparam int EDGE_RIGHT    = 2;

  localparam int NUM_GLB   = 8;
  localparam int NUM_FAST  = 2;
  localparam int COL_SEL_W = 4;
  localparam int CFG_W     = 5;
  localparam int DONE_BIT  = 4;

  typedef enum logic [1:0] {
    MODE_OFF_LO = 2'b00,
    MODE_PASS   = 2'b01,
    MODE_INV    = 2'b10,
    MODE_OFF_HI = 2'b11
  } sec_mode_e;

  typedef struct packed {
    logic      from_express;
    sec_mode_e mode;
  } sec_cfg_t;

  // Column choice: global lines first, then the edge fast pair if present.
  function automatic logic pick_column(input logic [COL_SEL_W-1:0] sel,
                                       input logic [NUM_GLB-1:0]   glb,
                                       input logic [NUM_FAST-1:0]  fast,
                                       input logic                 has_fast);
    logic r;
    r = 1'b0;
    if (sel < COL_SEL_W'(NUM_GLB))
      r = glb[sel[2:0]];
    else if (has_fast && sel < COL_SEL_W'(NUM_GLB + NUM_FAST))
      r = fast[sel[0]];
    return r;
  endfunction

  // Sector shaping: straight, inverted, or tied low.
  function automatic logic shape_sector(input logic src, input sec_mode_e mode);
    logic r;
    case (mode)
      MODE_PASS: r = src;
      MODE_INV:  r = ~src;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/colclk_cfg_regs.sv
module colclk_cfg_regs
  import colclk_pkg::*;
#(
  parameter int NSEC = 4,
  parameter int AW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         addr,
  input  logic [CFG_W-1:0]      wdata,
  output logic                  cfg_done,
  output logic [COL_SEL_W-1:0]  col_sel,
  output sec_cfg_t [NSEC-1:0]   sec_cfg
);

  logic               col_wr_hit;
  logic [NSEC-1:0]    sec_wr_hit;

  assign col_wr_hit = we && (addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_done <= 1'b0;
      col_sel  <= '0;
    end else if (col_wr_hit) begin
      cfg_done <= wdata[DONE_BIT];
      col_sel  <= wdata[COL_SEL_W-1:0];
    end
  end

  for (genvar k = 0; k < NSEC; k++) begin : g_sec_reg
    assign sec_wr_hit[k] = we && (addr == AW'(k + 1));

    always_ff @(posedge clk) begin
      if (!rst_n)
        sec_cfg[k] <= '0;
      else if (sec_wr_hit[k])
        sec_cfg[k] <= sec_cfg_t'(wdata[2:0]);
    end
  end

endmodule

// File: rtl/colclk_col_mux.sv
module colclk_col_mux
  import colclk_pkg::*;
#(
  parameter int EDGE_KIND = EDGE_INTERIOR
) (
  input  logic [COL_SEL_W-1:0] sel,
  input  logic [NUM_GLB-1:0]   glb_clk,
  input  logic [NUM_FAST-1:0]  fck_left,
  input  logic [NUM_FAST-1:0]  fck_right,
  output logic                 col_clk
);

  logic [NUM_FAST-1:0] fast_pair;
  logic                has_fast;

  if (EDGE_KIND == EDGE_LEFT) begin : g_left
    assign fast_pair = fck_left  & {NUM_FAST{1'b1}};
    assign has_fast  = 1'b1 | (|fck_right & 1'b0);
  end else if (EDGE_KIND == EDGE_RIGHT) begin : g_right
    assign fast_pair = fck_right & {NUM_FAST{1'b1}};
    assign has_fast  = 1'b1 | (|fck_left & 1'b0);
  end else begin : g_interior
    assign fast_pair = (fck_left & fck_right) & {NUM_FAST{1'b0}};
    assign has_fast  = 1'b0;
  end

  assign col_clk = pick_column(sel, glb_clk, fast_pair, has_fast);

endmodule

// File: rtl/colclk_sector.sv
module colclk_sector
  import colclk_pkg::*;
(
  input  logic     cfg_done,
  input  logic     col_clk,
  input  logic     express_in,
  input  sec_cfg_t cfg,
  output logic     sec_clk
);

  logic src_sel;

  assign src_sel = cfg.from_express ? express_in : col_clk;
  assign sec_clk = cfg_done & shape_sector(src_sel, cfg.mode);

endmodule

// File: rtl/colclk_router.sv
module colclk_router
  import colclk_pkg::*;
#(
  parameter int NUM_CELLS        = 16,
  parameter int CELLS_PER_SECTOR = 4,
  parameter int EDGE_KIND        = EDGE_INTERIOR,
  parameter int AW               = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [AW-1:0]                         cfg_addr,
  input  logic [CFG_W-1:0]                      cfg_wdata,
  input  logic [NUM_GLB-1:0]                    glb_clk,
  input  logic [NUM_FAST-1:0]                   fck_left,
  input  logic [NUM_FAST-1:0]                   fck_right,
  input  logic [NUM_CELLS/CELLS_PER_SECTOR-1:0] express,
  output logic [NUM_CELLS/CELLS_PER_SECTOR-1:0] sec_clk
);

  localparam int NSEC = NUM_CELLS / CELLS_PER_SECTOR;

  // Named internal wires, observed by the bound checker.
  logic                 cfg_done;
  logic [COL_SEL_W-1:0] col_sel;
  sec_cfg_t [NSEC-1:0]  sec_cfg;
  logic                 col_clk;

  colclk_cfg_regs #(
    .NSEC (NSEC),
    .AW   (AW)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .cfg_done (cfg_done),
    .col_sel  (col_sel),
    .sec_cfg  (sec_cfg)
  );

  colclk_col_mux #(
    .EDGE_KIND (EDGE_KIND)
  ) col_i (
    .sel       (col_sel),
    .glb_clk   (glb_clk),
    .fck_left  (fck_left),
    .fck_right (fck_right),
    .col_clk   (col_clk)
  );

  for (genvar k = 0; k < NSEC; k++) begin : g_sector
    colclk_sector sec_i (
      .cfg_done   (cfg_done),
      .col_clk    (col_clk),
      .express_in (express[k]),
      .cfg        (sec_cfg[k]),
      .sec_clk    (sec_clk[k])
    );
  end

endmodule

// File: rtl/colclk_router_chk.sv
module colclk_router_chk
  import colclk_pkg::*;
#(
  parameter int NSEC      = 4,
  parameter int EDGE_KIND = EDGE_INTERIOR
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_done,
  input logic [COL_SEL_W-1:0] col_sel,
  input logic                 col_clk,
  input sec_cfg_t [NSEC-1:0]  sec_cfg,
  input logic [NSEC-1:0]      express,
  input logic [NSEC-1:0]      sec_clk
);

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cfg_done && sec_clk == '0));

  assert_unconfigured_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> sec_clk == '0);

  assert_interior_no_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (EDGE_KIND == EDGE_INTERIOR && col_sel > 4'd7) |-> !col_clk);

  assert_high_code_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (col_sel > 4'd9) |-> !col_clk);

  for (genvar k = 0; k < NSEC; k++) begin : g_sec_chk
    assert_pass_follows_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !sec_cfg[k].from_express && sec_cfg[k].mode == MODE_PASS)
        |-> sec_clk[k] == col_clk);

    assert_invert_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && !sec_cfg[k].from_express && sec_cfg[k].mode == MODE_INV)
        |-> sec_clk[k] == !col_clk);

    assert_off_mode_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_cfg[k].mode == MODE_OFF_LO || sec_cfg[k].mode == MODE_OFF_HI)
        |-> !sec_clk[k]);

    assert_express_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_done && sec_cfg[k].from_express && sec_cfg[k].mode == MODE_PASS)
        |-> sec_clk[k] == express[k]);
  end

endmodule

bind colclk_router colclk_router_chk #(
  .NSEC      (NSEC),
  .EDGE_KIND (EDGE_KIND)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_done (cfg_done),
  .col_sel  (col_sel),
  .col_clk  (col_clk),
  .sec_cfg  (sec_cfg),
  .express  (express),
  .sec_clk  (sec_clk)
);

// File: tb/colclk_router_tb_top.sv
`timescale 1ns/100ps
module colclk_router_tb_top;

  localparam int NC  = 16;
  localparam int CPS = 4;
  localparam int NS  = NC / CPS;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [4:0]    cfg_wdata = '0;
  logic [7:0]    glb_clk = '0;
  logic [1:0]    fck_left = '0;
  logic [1:0]    fck_right = '0;
  logic [NS-1:0] express = '0;
  logic [NS-1:0] out_int, out_lft, out_rgt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Shadow of the configuration, kept from the register map of R8.
  logic       m_done;
  logic [3:0] m_col;
  logic [1:0] m_mode [NS];
  logic       m_src  [NS];

  always #2.5 clk = ~clk;

  colclk_router #(.NUM_CELLS(NC), .CELLS_PER_SECTOR(CPS), .EDGE_KIND(0), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .glb_clk(glb_clk), .fck_left(fck_left), .fck_right(fck_right), .express(express),
    .sec_clk(out_int));

  colclk_router #(.NUM_CELLS(NC), .CELLS_PER_SECTOR(CPS), .EDGE_KIND(1), .AW(AW)) dut_lft_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .glb_clk(glb_clk), .fck_left(fck_left), .fck_right(fck_right), .express(express),
    .sec_clk(out_lft));

  colclk_router #(.NUM_CELLS(NC), .CELLS_PER_SECTOR(CPS), .EDGE_KIND(2), .AW(AW)) dut_rgt_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .glb_clk(glb_clk), .fck_left(fck_left), .fck_right(fck_right), .express(express),
    .sec_clk(out_rgt));

  function automatic logic model_col(int kind);
    logic r;
    case (m_col)
      4'd8:    r = (kind == 1) ? fck_left[0] : (kind == 2) ? fck_right[0] : 1'b0;
      4'd9:    r = (kind == 1) ? fck_left[1] : (kind == 2) ? fck_right[1] : 1'b0;
      default: r = (m_col <= 4'd7) ? glb_clk[m_col[2:0]] : 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [NS-1:0] model_out(int kind);
    logic [NS-1:0] v;
    logic s;
    for (int k = 0; k < NS; k++) begin
      s = m_src[k] ? express[k] : model_col(kind);
      if (!m_done)               v[k] = 1'b0;
      else if (m_mode[k] == 2'b01) v[k] = s;
      else if (m_mode[k] == 2'b10) v[k] = !s;
      else                       v[k] = 1'b0;
    end
    return v;
  endfunction

  task automatic model_clear();
    m_done = 1'b0;
    m_col  = '0;
    for (int k = 0; k < NS; k++) begin
      m_mode[k] = 2'b00;
      m_src[k]  = 1'b0;
    end
  endtask

  task automatic check_all(string req);
    logic [NS-1:0] got [3];
    #1;
    got[0] = out_int; got[1] = out_lft; got[2] = out_rgt;
    for (int v = 0; v < 3; v++) begin
      checks++;
      if (got[v] !== model_out(v)) begin
        errors++;
        $display("FAIL %s variant %0d actual %b expected %b", req, v, got[v], model_out(v));
      end
    end
  endtask

  task automatic apply_reset(int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (cycles) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  task automatic cfg_write(int addr, logic [4:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr == 0) begin
      m_done = data[4];
      m_col  = data[3:0];
    end else if (addr <= NS) begin
      m_mode[addr-1] = data[1:0];
      m_src[addr-1]  = data[2];
    end
  endtask

  task automatic cfg_idle_poke(int addr, logic [4:0] data);
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
  endtask

  task automatic drive(logic [7:0] g, logic [1:0] fl, logic [1:0] fr, logic [NS-1:0] e);
    glb_clk = g; fck_left = fl; fck_right = fr; express = e;
  endtask

  // R1: reset state and reset during operation
  task automatic t_reset();
    drive(8'hFF, 2'b11, 2'b11, '1);
    @(negedge clk);
    check_all("R1 during reset");
    apply_reset(3);
    check_all("R1 after release");
    for (int k = 0; k < NS; k++) cfg_write(k + 1, 5'b00001);
    cfg_write(0, 5'b10000);
    check_all("R1 configured before re-reset");
    apply_reset(2);
    check_all("R1 mid-operation reset clears");
  endtask

  // R2: hold until configured, release shows mode results, clearing re-holds
  task automatic t_hold();
    apply_reset(2);
    drive(8'h01, 2'b00, 2'b00, '0);
    cfg_write(1, 5'b00001);
    cfg_write(2, 5'b00010);
    cfg_write(3, 5'b00000);
    cfg_write(4, 5'b00011);
    check_all("R2 hold while unconfigured");
    cfg_write(0, 5'b10000);
    check_all("R2 release gives mode results");
    drive(8'h00, 2'b00, 2'b00, '0);
    check_all("R2 released low column");
    cfg_write(0, 5'b00000);
    drive(8'hFF, 2'b00, 2'b00, '0);
    check_all("R2 flag cleared holds zero");
  endtask

  // R3: global line selection
  task automatic t_global();
    apply_reset(2);
    for (int k = 0; k < NS; k++) cfg_write(k + 1, 5'b00001);
    for (int s = 0; s < 8; s++) begin
      cfg_write(0, 5'(16 + s));
      drive(8'h01 << s, 2'b11, 2'b11, '0);
      check_all("R3 walking one");
      drive(~(8'h01 << s), 2'b11, 2'b11, '1);
      check_all("R3 walking zero");
    end
  endtask

  // R4: fast pair per variant
  task automatic t_fast();
    logic [1:0] pl [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
    for (int s = 8; s < 10; s++) begin
      cfg_write(0, 5'(16 + s));
      for (int p = 0; p < 4; p++) begin
        drive(8'hFF, pl[p], ~pl[p], '0);
        check_all("R4 edge fast clock");
      end
    end
  endtask

  // R5: out-of-range codes
  task automatic t_high();
    for (int s = 10; s < 16; s++) begin
      cfg_write(0, 5'(16 + s));
      drive(8'hFF, 2'b11, 2'b11, '0);
      check_all("R5 unused code zero");
    end
  endtask

  // R6, R9: all modes, sectors set differently at once
  task automatic t_modes();
    cfg_write(0, 5'b10011);
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < NS; k++) cfg_write(k + 1, 5'((c + k) % 4));
      drive(8'h08, 2'b00, 2'b00, '1);
      check_all("R6 R9 modes column high");
      drive(8'hF7, 2'b00, 2'b00, '1);
      check_all("R6 R9 modes column low");
    end
  endtask

  // R7: express source
  task automatic t_source();
    cfg_write(0, 5'b10101);
    for (int k = 0; k < NS; k++)
      cfg_write(k + 1, (k % 2 == 0) ? 5'b00101 : 5'b00110);
    for (int e = 0; e < (1 << NS); e++) begin
      drive((e % 3 == 0) ? 8'h20 : 8'h00, 2'b00, 2'b00, NS'(e));
      check_all("R7 express source");
    end
    cfg_write(2, 5'b00001);
    drive(8'h20, 2'b00, 2'b00, '0);
    check_all("R7 column source restored");
  endtask

  // R8, R10: stray addresses and idle cycles change nothing
  task automatic t_ignored();
    apply_reset(2);
    for (int k = 0; k < NS; k++) cfg_write(k + 1, 5'b00001);
    cfg_write(0, 5'b10010);
    drive(8'h04, 2'b00, 2'b00, '0);
    check_all("R8 baseline");
    for (int a = NS + 1; a < (1 << AW); a++) cfg_write(a, 5'b00000);
    check_all("R8 out-of-map writes ignored");
    cfg_idle_poke(0, 5'b00000);
    check_all("R10 idle poke to column register");
    cfg_idle_poke(1, 5'b00011);
    cfg_idle_poke(3, 5'b00010);
    check_all("R10 idle poke to sector registers");
    drive(8'h00, 2'b00, 2'b00, '0);
    check_all("R10 state intact low column");
  endtask

  initial begin
    model_clear();
    t_reset();
    t_hold();
    t_global();
    t_fast();
    t_high();
    t_modes();
    t_source();
    t_ignored();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule